// File: doc/BRIEF.md
# GPIO Bank Interrupt Cause Unit

This block is the interrupt side of a bank of general-purpose I/O lines. Every incoming line is synchronised. It is then passed through a per-line inversion bit, which gives the corrected input value. That corrected value feeds two cause paths:

- A level path, which follows the corrected input directly with no latching.
- An edge path, which records each rising transition of the corrected input in a sticky cause register.

Two independent mask registers gate the two paths. The gated causes of every group of consecutive lines are ORed into one summary interrupt per group. A top-level interrupt controller consumes these summary outputs.

Software reaches the block through a simple single-cycle register bus. Through this bus it sets the direction of each line and the value driven on output lines. It also sets the inversion bits and both masks, reads the current pin value, and acknowledges edge causes. To acknowledge, it writes a word that holds zero in the bits to clear and ones everywhere else. Detection of falling edges or active-low levels is done by setting a line's inversion bit.

Register select codes on `bus_addr` are fixed as follows:

| Code | Register |
|------|----------|
| 0 | Direction |
| 1 | Output value |
| 2 | Inversion |
| 3 | Pin value (read only) |
| 4 | Edge cause |
| 5 | Edge mask |
| 6 | Level mask |
| 7 | Unused, reads zero |

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads zero, `irq_grp` is all zero, `line_out` is zero and `line_drive_en` is all ones, so every line is an output.
- R2: A direction bit of 1 makes its line an input and clears its `line_drive_en` bit. A direction bit of 0 makes it an output, with `line_drive_en` set. `line_out` always equals the output-value register.
- R3: The corrected input of a line is its synchronised `line_in` bit XOR its inversion bit. A change on `line_in` reaches the corrected input after two rising clock edges.
- R4: The pin-value register (code 3) returns the corrected input for lines configured as inputs and the output-value bit for lines configured as outputs.
- R5: An input line whose level-mask bit is set drives its group's summary output for as long as its corrected input is 1, and releases it when the input returns to 0, with nothing latched.
- R6: A 0-to-1 transition of an input line's corrected input sets its edge-cause bit one cycle later. The bit stays set after the line returns low.
- R7: Writing the edge-cause register (code 4) clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R8: When a new edge on a line arrives in the same cycle as a write that clears that line's cause bit, the bit ends up set.
- R9: An edge-cause bit drives its group's summary output only while its edge-mask bit is set. A masked-off line still records its edge cause.
- R10: Summary output `irq_grp[g]` is the OR of the gated causes of lines 8g to 8g+7.
- R11: A line configured as an output produces neither a level cause nor a new edge cause, whatever its `line_in` value.
- R12: With its inversion bit set, a falling transition of `line_in` sets the line's edge-cause bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register select code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register, combinational |
| line_in | input | 32 | Asynchronous line inputs |
| line_out | output | 32 | Value driven on output lines |
| line_drive_en | output | 32 | Per-line output driver enable, 1 for output lines |
| irq_grp | output | 4 | One summary interrupt per group of eight lines |

## Verification
The assertions check the following on every cycle:

- Edge causes never fall without a write to the cause register.
- A cause write never clears a bit written as 1.
- Output-configured lines never gain a new edge cause.
- With both masks clear, no summary output rises.
- A live, enabled level cause always reaches a summary output.

The directed scenarios are the only place that shows the rest:

- The two-cycle synchronisation latency and the inversion results.
- The pin-value mux across directions.
- The mapping of lines to the correct group.
- Set winning over a clear in the same cycle, which the bench times exactly.
- Falling-edge detection through the inversion bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_DIR   = 3'd0,
    REG_OUT   = 3'd1,
    REG_POL   = 3'd2,
    REG_PIN   = 3'd3,
    REG_CAUSE = 3'd4,
    REG_EMASK = 3'd5,
    REG_LMASK = 3'd6
  } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_in,
  input  logic [WIDTH-1:0] qualify,
  input  logic             ack_we,
  input  logic [WIDTH-1:0] ack_keep,
  output logic [WIDTH-1:0] cause
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] cause_q;
  logic [WIDTH-1:0] cause_d;
  logic [WIDTH-1:0] rise;

  assign rise = level_in & ~prev_q & qualify;

  // A new rise is ORed in after the acknowledge mask, so a set beats a clear.
  always_comb begin
    cause_d = cause_q;
    if (ack_we) begin
      cause_d = cause_q & ack_keep;
    end
    cause_d = cause_d | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= level_in;
      cause_q <= cause_d;
    end
  end

  assign cause = cause_q;

endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
  parameter int WIDTH      = 32,
  parameter int GROUP_SIZE = 8
) (
  input  logic [WIDTH-1:0]            src,
  output logic [WIDTH/GROUP_SIZE-1:0] grp
);

  localparam int NUM_GROUPS = WIDTH / GROUP_SIZE;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp[g] = |src[g*GROUP_SIZE +: GROUP_SIZE];
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int GROUP_SIZE  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic [REG_ADDR_W-1:0]           bus_addr,
  input  logic [NUM_LINES-1:0]            bus_wdata,
  output logic [NUM_LINES-1:0]            bus_rdata,
  input  logic [NUM_LINES-1:0]            line_in,
  output logic [NUM_LINES-1:0]            line_out,
  output logic [NUM_LINES-1:0]            line_drive_en,
  output logic [NUM_LINES/GROUP_SIZE-1:0] irq_grp
);

  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE;

  logic [NUM_LINES-1:0] dir_q,   dir_d;
  logic [NUM_LINES-1:0] out_q,   out_d;
  logic [NUM_LINES-1:0] pol_q,   pol_d;
  logic [NUM_LINES-1:0] emask_q, emask_d;
  logic [NUM_LINES-1:0] lmask_q, lmask_d;

  logic                 wr_dir, wr_out, wr_pol, wr_emask, wr_lmask, wr_cause;
  logic [NUM_LINES-1:0] line_sync;
  logic [NUM_LINES-1:0] data_in;
  logic [NUM_LINES-1:0] edge_cause;
  logic [NUM_LINES-1:0] pin_val;
  logic [NUM_LINES-1:0] gated_cause;

  // Write decode
  assign wr_dir   = bus_wr && (bus_addr == REG_DIR);
  assign wr_out   = bus_wr && (bus_addr == REG_OUT);
  assign wr_pol   = bus_wr && (bus_addr == REG_POL);
  assign wr_emask = bus_wr && (bus_addr == REG_EMASK);
  assign wr_lmask = bus_wr && (bus_addr == REG_LMASK);
  assign wr_cause = bus_wr && (bus_addr == REG_CAUSE);

  always_comb begin
    dir_d   = dir_q;
    out_d   = out_q;
    pol_d   = pol_q;
    emask_d = emask_q;
    lmask_d = lmask_q;
    if (wr_dir)   dir_d   = bus_wdata;
    if (wr_out)   out_d   = bus_wdata;
    if (wr_pol)   pol_d   = bus_wdata;
    if (wr_emask) emask_d = bus_wdata;
    if (wr_lmask) lmask_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else begin
      dir_q   <= dir_d;
      out_q   <= out_d;
      pol_q   <= pol_d;
      emask_q <= emask_d;
      lmask_q <= lmask_d;
    end
  end

  gpio_sync #(
    .WIDTH (NUM_LINES),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(line_in),
    .sync_out(line_sync)
  );

  // Inversion ahead of both cause paths
  assign data_in = line_sync ^ pol_q;

  gpio_edge_cause #(
    .WIDTH(NUM_LINES)
  ) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_in(data_in),
    .qualify (dir_q),
    .ack_we  (wr_cause),
    .ack_keep(bus_wdata),
    .cause   (edge_cause)
  );

  assign gated_cause = (data_in & dir_q & lmask_q) | (edge_cause & emask_q);

  gpio_group_or #(
    .WIDTH     (NUM_LINES),
    .GROUP_SIZE(GROUP_SIZE)
  ) u_grp (
    .src(gated_cause),
    .grp(irq_grp)
  );

  assign pin_val = (data_in & dir_q) | (out_q & ~dir_q);

  // Read mux
  always_comb begin
    case (bus_addr)
      REG_DIR:   bus_rdata = dir_q;
      REG_OUT:   bus_rdata = out_q;
      REG_POL:   bus_rdata = pol_q;
      REG_PIN:   bus_rdata = pin_val;
      REG_CAUSE: bus_rdata = edge_cause;
      REG_EMASK: bus_rdata = emask_q;
      REG_LMASK: bus_rdata = lmask_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign line_out      = out_q;
  assign line_drive_en = ~dir_q;

  if (NUM_GROUPS * GROUP_SIZE != NUM_LINES) begin : g_bad_cfg
    initial $error("NUM_LINES must be a multiple of GROUP_SIZE");
  end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int NUM_GROUPS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [REG_ADDR_W-1:0] bus_addr,
  input logic [NUM_LINES-1:0]  bus_wdata,
  input logic [NUM_LINES-1:0]  dir_q,
  input logic [NUM_LINES-1:0]  lmask_q,
  input logic [NUM_LINES-1:0]  emask_q,
  input logic [NUM_LINES-1:0]  data_in,
  input logic [NUM_LINES-1:0]  edge_cause,
  input logic [NUM_GROUPS-1:0] irq_grp
);

  logic cause_wr;
  assign cause_wr = bus_wr && (bus_addr == REG_CAUSE);

  a_r6_sticky_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |=> (($past(edge_cause) & ~edge_cause) == '0));

  a_r7_ones_keep: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr |=> (($past(edge_cause & bus_wdata) & ~edge_cause) == '0));

  a_r11_output_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(dir_q) & edge_cause & ~$past(edge_cause)) == '0));

  a_r10_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((lmask_q == '0) && (emask_q == '0)) |-> (irq_grp == '0));

  a_r5_level_reaches: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_in & dir_q & lmask_q) != '0) |-> (irq_grp != '0));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NUM_LINES (NUM_LINES),
  .NUM_GROUPS(NUM_LINES / GROUP_SIZE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .dir_q     (dir_q),
  .lmask_q   (lmask_q),
  .emask_q   (emask_q),
  .data_in   (data_in),
  .edge_cause(edge_cause),
  .irq_grp   (irq_grp)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] line_in;
  logic [31:0] line_out;
  logic [31:0] line_drive_en;
  logic [3:0]  irq_grp;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  localparam logic [2:0] A_DIR = 3'd0, A_OUT = 3'd1, A_POL = 3'd2, A_PIN = 3'd3,
                         A_CAUSE = 3'd4, A_EMASK = 3'd5, A_LMASK = 3'd6;

  gpio_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in),
    .line_out(line_out), .line_drive_en(line_drive_en), .irq_grp(irq_grp)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic drive_lines(input logic [31:0] v);
    @(negedge clk);
    line_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R1 register reset", v, 32'h0);
    end
    chk("R1 irq reset", {28'h0, irq_grp}, 32'h0);
    chk("R1 drive_en reset", line_drive_en, 32'hFFFF_FFFF);
    chk("R1 line_out reset", line_out, 32'h0);
  endtask

  task automatic t_direction;
    logic [31:0] v;
    wr(A_OUT, 32'hA5A5_5A5A);
    wr(A_DIR, 32'h0000_FFFF);
    drive_lines(32'h0000_1234);
    chk("R2 line_out", line_out, 32'hA5A5_5A5A);
    chk("R2 drive_en", line_drive_en, 32'hFFFF_0000);
    rd(A_PIN, v);
    chk("R4 pin value mix", v, 32'hA5A5_1234);
  endtask

  task automatic t_polarity;
    logic [31:0] v;
    wr(A_DIR, 32'hFFFF_FFFF);
    wr(A_POL, 32'h0F0F_0F0F);
    @(negedge clk);
    line_in = 32'h1234_5678;
    @(negedge clk);
    rd(A_PIN, v);
    chk("R3 pin after 2 edges", v, 32'h1D3B_5977);
    wr(A_POL, 32'h0);
    drive_lines(32'h0);
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, v);
    chk("R7 clear all", v, 32'h0);
  endtask

  task automatic t_level;
    wr(A_LMASK, 32'h8000_0100);
    drive_lines(32'h0000_0100);
    chk("R5 R10 level group1", {28'h0, irq_grp}, 32'h2);
    drive_lines(32'h8000_0000);
    chk("R5 R10 level group3, no latch", {28'h0, irq_grp}, 32'h8);
    drive_lines(32'h0);
    chk("R5 level release", {28'h0, irq_grp}, 32'h0);
    wr(A_LMASK, 32'h0);
    wr(A_CAUSE, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(A_EMASK, 32'h0010_0000);
    drive_lines(32'h0010_0008);
    drive_lines(32'h0);
    rd(A_CAUSE, v);
    chk("R6 R9 sticky causes", v, 32'h0010_0008);
    chk("R9 R10 edge group2 only", {28'h0, irq_grp}, 32'h4);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(A_CAUSE, 32'hFFEF_FFFF);
    rd(A_CAUSE, v);
    chk("R7 single-line ack", v, 32'h0000_0008);
    chk("R7 irq after ack", {28'h0, irq_grp}, 32'h0);
    wr(A_CAUSE, 32'hFFFF_FFFF);
    rd(A_CAUSE, v);
    chk("R7 ones keep", v, 32'h0000_0008);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    @(negedge clk);
    line_in = 32'h0200_0000;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_CAUSE; bus_wdata = 32'h0;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(A_CAUSE, v);
    chk("R8 set beats clear", v, 32'h0200_0000);
    drive_lines(32'h0);
    wr(A_CAUSE, 32'h0);
    wr(A_EMASK, 32'h0);
  endtask

  task automatic t_output_line;
    logic [31:0] v;
    wr(A_DIR, 32'hFFFF_FFDF);
    wr(A_LMASK, 32'h20);
    wr(A_EMASK, 32'h20);
    drive_lines(32'h20);
    chk("R11 no level irq", {28'h0, irq_grp}, 32'h0);
    rd(A_CAUSE, v);
    chk("R11 no edge cause", v, 32'h0);
    drive_lines(32'h0);
    wr(A_DIR, 32'hFFFF_FFFF);
    wr(A_LMASK, 32'h0);
    wr(A_EMASK, 32'h0);
  endtask

  task automatic t_falling;
    logic [31:0] v;
    drive_lines(32'h0000_1000);
    wr(A_POL, 32'h0000_1000);
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, v);
    chk("R12 inversion to low adds no edge", v, 32'h0);
    wr(A_EMASK, 32'h0000_1000);
    drive_lines(32'h0);
    rd(A_CAUSE, v);
    chk("R12 falling edge captured", v, 32'h0000_1000);
    chk("R12 falling irq group1", {28'h0, irq_grp}, 32'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 32'h0; line_in = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_polarity();
    t_level();
    t_edge();
    t_clear();
    t_priority();
    t_output_line();
    t_falling();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule